// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor

This block is a 32-bit processor that completes one instruction in every clock cycle. In that cycle it fetches the instruction, decodes it, reads its operands, computes a result and writes the result back, and it moves the program counter on. It runs a twelve-instruction integer subset of the RISC-V base set, using the standard 32-bit encodings. The subset covers register-register and register-immediate add, subtract, AND, OR and signed set-less-than, plus word load, word store and branch-if-equal. The processor contains a program counter, a 32-entry register file, an immediate generator, an ALU, a decoder, an instruction store and a word-wide data store.

The instruction store holds one byte per entry. A fetch reads four consecutive entries and puts the lowest-addressed byte in the top bits of the instruction. The only pins are the clock and an active-low reset. A test environment places a program by writing `u_imem.mem` and reads the architectural state through `u_rf.regs` and `u_dmem.mem`. These names are fixed for that purpose.

Top module: `rvs_core`

## Requirements
- R1: At each rising edge where `rst_n` is 0, the program counter becomes 0 and all 32 registers become 0.
- R2: A fetch joins four instruction-store entries. The entry at the PC supplies bits [31:24], PC+1 supplies bits [23:16], PC+2 supplies bits [15:8] and PC+3 supplies bits [7:0]. For example, the bytes 0x0A, 0x30, 0x04, 0x13 form addi x8, x0, 163.
- R3: When no branch is taken, the PC grows by 4 at each rising edge after reset.
- R4: add, sub, and and or (opcode 0110011; funct3 000/000/111/110; funct7 0000000, or 0100000 for sub) write rs1 op rs2 to rd.
- R5: slt (R-type, funct3 010) and slti (opcode 0010011, funct3 010) write 1 when rs1 is less than the second operand as two's-complement numbers, and 0 otherwise.
- R6: addi, andi and ori (opcode 0010011; funct3 000/111/110) use the 12-bit immediate in bits [31:20], sign-extended to 32 bits.
- R7: Register x0 always reads as 0. A write to it has no effect.
- R8: sw (opcode 0100011, funct3 010) stores rs2 at rs1 + the S-type immediate. lw (opcode 0000011, funct3 010) loads from rs1 + the I-type immediate. The data word is selected by address bits above bit 1.
- R9: beq (opcode 1100011, funct3 000) with rs1 equal to rs2 sets the PC to PC + the sign-extended B-type offset. Forward and backward offsets both work. With unequal operands the PC grows by 4.
- R10: An unknown opcode, or a known opcode with an unsupported funct3 or funct7, writes no register and no memory, and the PC grows by 4.
- R11: sw and beq never write a register, whatever bits [11:7] hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge. |

## Verification
The checker watches the control side on every cycle. It checks that the PC is cleared during reset and steps by 4 whenever no branch is taken. It checks that x0 reads as zero, that stores and branches never raise the register write enable, and that an unknown opcode raises no write enable and takes no branch. The data path can only be judged through the bench's programs. Those programs cover signed comparison results, immediate sign extension, load and store addressing, forward and backward branches, the byte order of the fetch, and the rejection of unsupported funct fields. The bench checks each of these through the register values after the relevant instructions have run.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   localparam logic [2:0] F3_ADD = 3'b000;
   localparam logic [2:0] F3_SLT = 3'b010;
   localparam logic [2:0] F3_OR  = 3'b110;
   localparam logic [2:0] F3_AND = 3'b111;
   localparam logic [2:0] F3_WORD = 3'b010;
   localparam logic [2:0] F3_EQ  = 3'b000;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_I,
      IMM_S,
      IMM_B
   } imm_kind_e;

   typedef struct packed {
      logic      rf_we;
      logic      use_imm;
      logic      mem_we;
      logic      mem_rd;
      logic      is_beq;
      imm_kind_e imm_kind;
      alu_op_e   alu_op;
   } ctrl_t;

endpackage

// File: rtl/rvs_decode.sv
module rvs_decode
   import rvs_pkg::*;
(
   input  logic [31:0] instr,
   output ctrl_t       ctrl
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];
   assign f7  = instr[31:25];

   always_comb begin
      ctrl          = '0;
      ctrl.imm_kind = IMM_I;
      ctrl.alu_op   = ALU_ADD;
      unique case (opc)
         OPC_REG: begin
            if (f7 == F7_BASE) begin
               unique case (f3)
                  F3_ADD: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                  F3_AND: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_AND; end
                  F3_OR:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_OR;  end
                  F3_SLT: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                  default: ;
               endcase
            end else if (f7 == F7_ALT && f3 == F3_ADD) begin
               ctrl.rf_we  = 1'b1;
               ctrl.alu_op = ALU_SUB;
            end
         end
         OPC_IMM: begin
            ctrl.use_imm  = 1'b1;
            ctrl.imm_kind = IMM_I;
            unique case (f3)
               F3_ADD: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD; end
               F3_AND: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_AND; end
               F3_OR:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_OR;  end
               F3_SLT: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SLT; end
               default: ;
            endcase
         end
         OPC_LOAD: begin
            if (f3 == F3_WORD) begin
               ctrl.rf_we    = 1'b1;
               ctrl.use_imm  = 1'b1;
               ctrl.mem_rd   = 1'b1;
               ctrl.imm_kind = IMM_I;
            end
         end
         OPC_STORE: begin
            if (f3 == F3_WORD) begin
               ctrl.mem_we   = 1'b1;
               ctrl.use_imm  = 1'b1;
               ctrl.imm_kind = IMM_S;
            end
         end
         OPC_BRANCH: begin
            if (f3 == F3_EQ) begin
               ctrl.is_beq   = 1'b1;
               ctrl.imm_kind = IMM_B;
               ctrl.alu_op   = ALU_SUB;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rvs_immgen.sv
module rvs_immgen
   import rvs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     instr,
   input  imm_kind_e       kind,
   output logic [XLEN-1:0] imm
);

   localparam int EXT_I = XLEN - 12;
   localparam int EXT_B = XLEN - 13;

   logic [XLEN-1:0] imm_i;
   logic [XLEN-1:0] imm_s;
   logic [XLEN-1:0] imm_b;
   logic [6:0]      unused_opc;

   assign unused_opc = instr[6:0];

   assign imm_i = {{EXT_I{instr[31]}}, instr[31:20]};
   assign imm_s = {{EXT_I{instr[31]}}, instr[31:25], instr[11:7]};
   assign imm_b = {{EXT_B{instr[31]}}, instr[31], instr[7], instr[30:25],
                   instr[11:8], 1'b0};

   always_comb begin
      unique case (kind)
         IMM_S:   imm = imm_s;
         IMM_B:   imm = imm_b;
         default: imm = imm_i;
      endcase
   end

endmodule

// File: rtl/rvs_alu.sv
module rvs_alu
   import rvs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   logic [XLEN-1:0] diff;
   logic            lt_s;

   assign diff = a - b;
   assign lt_s = $signed(a) < $signed(b);

   always_comb begin
      unique case (op)
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_s};
         default: y = a + b;
      endcase
   end

   assign zero = (diff == '0);

endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int NRD  = 2,
   localparam int IW  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NRD-1:0][IW-1:0]   ra,
   output logic [NRD-1:0][XLEN-1:0] rdata,
   input  logic                     we,
   input  logic [IW-1:0]            wa,
   input  logic [XLEN-1:0]          wdata
);

   if (NREG != 32) begin : g_bad_nreg
      $error("rvs_regfile: NREG must be 32");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("rvs_regfile: NRD must be at least 1");
   end

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && wa != '0) begin
         regs[wa] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
   end

endmodule

// File: rtl/rvs_imem.sv
module rvs_imem #(
   parameter int BYTES = 256,
   parameter int XLEN  = 32,
   localparam int AW   = $clog2(BYTES),
   localparam int NB   = XLEN / 8
) (
   input  logic [XLEN-1:0] addr,
   output logic [XLEN-1:0] instr
);

   if ((1 << AW) != BYTES) begin : g_bad_bytes
      $error("rvs_imem: BYTES must be a power of two");
   end
   if (BYTES < NB) begin : g_small
      $error("rvs_imem: BYTES must hold one instruction");
   end

   logic [7:0]      mem [BYTES];
   logic [AW-1:0]   base;
   logic [XLEN-1:0] unused_addr;

   initial begin
      for (int i = 0; i < BYTES; i++) mem[i] = 8'h00;
   end

   assign base        = addr[AW-1:0];
   assign unused_addr = addr;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [AW-1:0] loc;
      assign loc = base + AW'(b);
      assign instr[XLEN-1-8*b -: 8] = mem[loc];
   end

endmodule

// File: rtl/rvs_dmem.sv
module rvs_dmem #(
   parameter int XLEN  = 32,
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);

   if ((1 << AW) != WORDS) begin : g_bad_words
      $error("rvs_dmem: WORDS must be a power of two");
   end

   logic [XLEN-1:0] mem [WORDS];
   logic [AW-1:0]   idx;
   logic [XLEN-1:0] unused_addr;

   assign idx         = addr[AW+1:2];
   assign unused_addr = addr;

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/rvs_core.sv
module rvs_core
   import rvs_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int IMEM_BYTES  = 256,
   parameter int DMEM_WORDS  = 64,
   parameter int NREG        = 32
) (
   input  logic clk,
   input  logic rst_n
);

   localparam int IW = $clog2(NREG);

   if (XLEN != 32) begin : g_bad_xlen
      $error("rvs_core: XLEN must be 32");
   end

   logic [XLEN-1:0]          pc_q;
   logic [XLEN-1:0]          pc_next;
   logic [XLEN-1:0]          instr;
   ctrl_t                    ctrl;
   logic [XLEN-1:0]          imm;
   logic [1:0][IW-1:0]       ra;
   logic [1:0][XLEN-1:0]     rv;
   logic [XLEN-1:0]          alu_b;
   logic [XLEN-1:0]          alu_y;
   logic                     alu_zero;
   logic [XLEN-1:0]          ld_data;
   logic [XLEN-1:0]          wb_data;
   logic                     br_taken;
   logic                     rf_we;
   logic                     mem_we;
   logic [IW-1:0]            rs1_idx;
   logic [XLEN-1:0]          rs1_val;

   rvs_imem #(.BYTES(IMEM_BYTES), .XLEN(XLEN)) u_imem (
      .addr  (pc_q),
      .instr (instr)
   );

   rvs_decode u_dec (
      .instr (instr),
      .ctrl  (ctrl)
   );

   rvs_immgen #(.XLEN(XLEN)) u_imm (
      .instr (instr),
      .kind  (ctrl.imm_kind),
      .imm   (imm)
   );

   assign ra[0]   = instr[19:15];
   assign ra[1]   = instr[24:20];
   assign rs1_idx = ra[0];
   assign rs1_val = rv[0];
   assign rf_we   = ctrl.rf_we;
   assign mem_we  = ctrl.mem_we;

   rvs_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra    (ra),
      .rdata (rv),
      .we    (rf_we),
      .wa    (instr[11:7]),
      .wdata (wb_data)
   );

   assign alu_b = ctrl.use_imm ? imm : rv[1];

   rvs_alu #(.XLEN(XLEN)) u_alu (
      .a    (rv[0]),
      .b    (alu_b),
      .op   (ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   rvs_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (alu_y),
      .wdata (rv[1]),
      .rdata (ld_data)
   );

   assign wb_data  = ctrl.mem_rd ? ld_data : alu_y;
   assign br_taken = ctrl.is_beq & alu_zero;
   assign pc_next  = br_taken ? (pc_q + imm) : (pc_q + XLEN'(4));

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

endmodule

// File: rtl/rvs_core_chk.sv
module rvs_core_chk
   import rvs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] pc,
   input logic [6:0]      opcode,
   input logic            rf_we,
   input logic            mem_we,
   input logic            br_taken,
   input logic [4:0]      rs1_idx,
   input logic [XLEN-1:0] rs1_val
);

   logic known_opc;
   assign known_opc = (opcode == OPC_REG) || (opcode == OPC_IMM) ||
                      (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                      (opcode == OPC_BRANCH);

   AST_RESET_PC: assert property (@(posedge clk)
      !rst_n |=> pc == '0);  // R1

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |=> pc == $past(pc) + XLEN'(4));  // R3

   AST_X0_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rs1_idx == 5'd0 |-> rs1_val == '0);  // R7

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !rf_we);  // R11

   AST_BRANCH_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OPC_BRANCH |-> !rf_we && !mem_we);  // R11

   AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !known_opc |-> !rf_we && !mem_we && !br_taken);  // R10

endmodule

bind rvs_core rvs_core_chk #(.XLEN(XLEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pc       (pc_q),
   .opcode   (instr[6:0]),
   .rf_we    (rf_we),
   .mem_we   (mem_we),
   .br_taken (br_taken),
   .rs1_idx  (rs1_idx),
   .rs1_val  (rs1_val)
);

// File: tb/test_rvs_core.sv
module test_rvs_core;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_tests = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   rvs_core i_rvs_core (
      .clk   (clk),
      .rst_n (rst_n)
   );

   // ---------------- encoders ----------------
   function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2,
                                         input int rs1, input logic [2:0] f3,
                                         input int rd);
      return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_i(input int imm, input int rs1,
                                         input logic [2:0] f3, input int rd,
                                         input logic [6:0] op);
      return {12'(imm), 5'(rs1), f3, 5'(rd), op};
   endfunction
   function automatic logic [31:0] enc_s(input int imm, input int rs2,
                                         input int rs1, input logic [2:0] f3);
      logic [11:0] v;
      v = 12'(imm);
      return {v[11:5], 5'(rs2), 5'(rs1), f3, v[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_b(input int off, input int rs2, input int rs1);
      logic [12:0] v;
      v = 13'(off);
      return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'b000, v[4:1], v[11], 7'b1100011};
   endfunction

   function automatic logic [31:0] i_add(int rd, int a, int b);  return enc_r(7'h00, b, a, 3'b000, rd); endfunction
   function automatic logic [31:0] i_sub(int rd, int a, int b);  return enc_r(7'h20, b, a, 3'b000, rd); endfunction
   function automatic logic [31:0] i_and(int rd, int a, int b);  return enc_r(7'h00, b, a, 3'b111, rd); endfunction
   function automatic logic [31:0] i_or(int rd, int a, int b);   return enc_r(7'h00, b, a, 3'b110, rd); endfunction
   function automatic logic [31:0] i_slt(int rd, int a, int b);  return enc_r(7'h00, b, a, 3'b010, rd); endfunction
   function automatic logic [31:0] i_addi(int rd, int a, int k); return enc_i(k, a, 3'b000, rd, 7'b0010011); endfunction
   function automatic logic [31:0] i_andi(int rd, int a, int k); return enc_i(k, a, 3'b111, rd, 7'b0010011); endfunction
   function automatic logic [31:0] i_ori(int rd, int a, int k);  return enc_i(k, a, 3'b110, rd, 7'b0010011); endfunction
   function automatic logic [31:0] i_slti(int rd, int a, int k); return enc_i(k, a, 3'b010, rd, 7'b0010011); endfunction
   function automatic logic [31:0] i_lw(int rd, int a, int k);   return enc_i(k, a, 3'b010, rd, 7'b0000011); endfunction
   function automatic logic [31:0] i_sw(int src, int a, int k);  return enc_s(k, src, a, 3'b010); endfunction
   function automatic logic [31:0] i_beq(int a, int b, int off); return enc_b(off, b, a); endfunction

   // ------------- straight-line vector table -------------
   // each entry: instruction, register checked one edge later, expected value, requirement
   localparam int NV = 19;
   localparam logic [31:0] V_INS [NV] = '{
      i_addi(1, 0, -5),      // R6
      i_addi(2, 0, 7),       // R6
      i_add(3, 1, 2),        // R4
      i_sub(4, 1, 2),        // R4
      i_and(5, 1, 2),        // R4
      i_or(6, 1, 2),         // R4
      i_slt(7, 1, 2),        // R5
      i_slt(8, 2, 1),        // R5
      i_slti(9, 1, -4),      // R5
      i_slti(10, 2, -1),     // R5
      i_andi(11, 2, -2),     // R6
      i_ori(12, 2, -16),     // R6
      i_sw(4, 2, 9),         // R11: rd field holds 9
      i_lw(13, 2, 9),        // R8
      i_sw(3, 0, 0),         // R8
      i_lw(14, 0, 0),        // R8
      i_add(0, 1, 2),        // R7
      i_beq(1, 2, 8),        // R9 not taken
      i_addi(15, 0, 1)       // R9/R3 sequential follow-on
   };
   localparam int V_RD [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 9, 13, 3, 14, 0, 15, 15};
   localparam logic [31:0] V_EXP [NV] = '{
      32'hFFFF_FFFB, 32'd7, 32'd2, 32'hFFFF_FFF4, 32'd3, 32'hFFFF_FFFF,
      32'd1, 32'd0, 32'd1, 32'd0, 32'd6, 32'hFFFF_FFF7,
      32'd1, 32'hFFFF_FFF4, 32'd2, 32'd2, 32'd0, 32'd0, 32'd1
   };
   localparam int V_REQ [NV] = '{6, 6, 4, 4, 4, 4, 5, 5, 5, 5, 6, 6, 11, 8, 8, 8, 7, 9, 3};

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] reg_of(input int k);
      return i_rvs_core.u_rf.regs[k];
   endfunction

   task automatic clear_imem();
      for (int k = 0; k < 256; k++) i_rvs_core.u_imem.mem[k] = 8'h00;
   endtask

   task automatic put_word(input int idx, input logic [31:0] w);
      i_rvs_core.u_imem.mem[4*idx+0] = w[31:24];
      i_rvs_core.u_imem.mem[4*idx+1] = w[23:16];
      i_rvs_core.u_imem.mem[4*idx+2] = w[15:8];
      i_rvs_core.u_imem.mem[4*idx+3] = w[7:0];
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic run_cycles(input int n);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      #1;
      clear_imem();
      for (int i = 0; i < NV; i++) put_word(i, V_INS[i]);
      repeat (3) @(posedge clk);
      #2;
      // R1: register file cleared under reset
      for (int k = 0; k < 32; k++) check("R1 reset reg", reg_of(k), 32'd0);

      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         #2;
         check($sformatf("R%0d vector %0d", V_REQ[i], i), reg_of(V_RD[i]), V_EXP[i]);
      end

      // R1: reset from a busy state clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      check("R1 x1 after reset", reg_of(1), 32'd0);
      check("R1 x13 after reset", reg_of(13), 32'd0);

      // R2: raw byte order of a fetch
      clear_imem();
      i_rvs_core.u_imem.mem[0] = 8'h0A;
      i_rvs_core.u_imem.mem[1] = 8'h30;
      i_rvs_core.u_imem.mem[2] = 8'h04;
      i_rvs_core.u_imem.mem[3] = 8'h13;
      enter_reset();
      run_cycles(1);
      check("R2 byte order x8", reg_of(8), 32'd163);

      // R9: forward taken, not taken, backward loop
      enter_reset();
      clear_imem();
      put_word(0,  i_addi(1, 0, 5));
      put_word(1,  i_beq(1, 1, 8));
      put_word(2,  i_addi(2, 0, 1));
      put_word(3,  i_addi(3, 0, 2));
      put_word(4,  i_beq(0, 1, 8));
      put_word(5,  i_addi(4, 0, 3));
      put_word(6,  i_addi(5, 5, 1));
      put_word(7,  i_slti(6, 5, 2));
      put_word(8,  i_beq(6, 0, 8));
      put_word(9,  i_beq(0, 0, -12));
      put_word(10, i_addi(8, 0, 7));
      run_cycles(16);
      check("R9 taken skips x2", reg_of(2), 32'd0);
      check("R9 target x3", reg_of(3), 32'd2);
      check("R9 not taken x4", reg_of(4), 32'd3);
      check("R9 backward x5", reg_of(5), 32'd2);
      check("R9 loop exit x6", reg_of(6), 32'd0);
      check("R9 after loop x8", reg_of(8), 32'd7);

      // R10: unknown opcode and unsupported funct fields
      enter_reset();
      clear_imem();
      put_word(0, i_addi(1, 0, 9));
      put_word(1, i_sw(1, 0, 0));
      put_word(2, 32'h0000_010B);
      put_word(3, enc_r(7'h00, 1, 1, 3'b001, 3));
      put_word(4, enc_i(5, 1, 3'b100, 4, 7'b0010011));
      put_word(5, enc_i(0, 0, 3'b000, 5, 7'b0000011));
      put_word(6, enc_s(0, 0, 0, 3'b000));
      put_word(7, i_lw(6, 0, 0));
      put_word(8, enc_r(7'h01, 1, 1, 3'b000, 10));
      put_word(9, i_addi(7, 0, 1));
      run_cycles(10);
      check("R10 custom opcode x2", reg_of(2), 32'd0);
      check("R10 shift funct x3", reg_of(3), 32'd0);
      check("R10 xor funct x4", reg_of(4), 32'd0);
      check("R10 byte load x5", reg_of(5), 32'd0);
      check("R10 byte store ignored x6", reg_of(6), 32'd9);
      check("R10 bad funct7 x10", reg_of(10), 32'd0);
      check("R10 pc kept stepping x7", reg_of(7), 32'd1);

      finish_run();
   end

endmodule